// File: doc/BRIEF.md
# Masked-Write GPIO Port Register Bank

This block holds the control and observation registers for one bank of 32 general-purpose pins. The pins are grouped as four 8-bit ports. For each port, software can configure the pin mode, the output enable and the output data. It can also read the synchronized pin levels, read the interrupt status that an external detector supplies, and program the interrupt enable and type bits that the detector uses. A write to a clear register produces a one-cycle clear strobe per pin for that detector.

The block answers at two address windows. In the plain window, a write replaces all eight bits of a port register. The second window, the masked window, sits a parameterized distance above the plain one. A write there carries a per-pin write mask, so single pins can change without a read-modify-write sequence. The bank's base address is its index times the bank stride. Both the stride and the masked-window distance are parameters, so different chip layouts (for example stride 0x80 with distance 0x800, or stride 0x100 with distance 0x80) use the same RTL.

Top module: `gpio_mask_bank`

## Requirements
- R1: After reset every stored register bit is 0: pin mode, output enable, output data, interrupt enable and interrupt type. Therefore pin_oe, pin_out, irq_en and irq_type are 0, and the input register reads 0 until pin levels have passed the synchronizer.
- R2: In the plain window (base B = BANK_ID*BANK_STRIDE), port p at byte offset B + kind + 4*p holds the following register kinds: 0x00 pin mode, 0x10 output enable, 0x20 output data, 0x30 input, 0x40 interrupt status, 0x50 interrupt enable, 0x60 interrupt type and 0x70 clear. Address bits 1:0 are ignored. A write to pin mode, output enable, output data, interrupt enable or interrupt type stores wdata[7:0], and a read returns the stored byte in rdata[7:0] with the upper bits 0.
- R3: In the masked window at B + ALT_OFFSET, a write to pin mode, output enable, output data, interrupt enable or interrupt type updates bit n from wdata[n] only where wdata[8+n] is 1. Bits with a 0 mask keep their value. Reads in this window return the same bytes as the plain window.
- R4: In the masked window, input and clear have no register. Writes there change nothing and raise no clear strobe, and reads there return 0.
- R5: A plain-window write to the clear register of port p drives irq_clr[8p+n] = wdata[n] during the write cycle only, and stores nothing. The clear register always reads 0.
- R6: The interrupt-status register of port p reads irq_sta[8p+7:8p] in both windows. Writes to it are ignored.
- R7: The input register of port p reads pin_in[8p+7:8p] after a two-flop synchronizer. A level present at clock edge k is readable after edge k+1.
- R8: pin_oe[i] is 1 exactly when both pin-mode bit i and output-enable bit i are 1. pin_out[i] equals output-data bit i when pin_oe[i] is 1, and 0 otherwise.
- R9: Addresses outside both windows ignore writes and read 0.
- R10: irq_en and irq_type continuously present the stored interrupt enable and type bits, with bit 8p+n belonging to pin n of port p.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the current address |
| addr | input | AW | Byte address |
| wdata | input | 32 | Write data; masked window uses [15:8] as mask, [7:0] as values |
| rdata | output | 32 | Read data for addr, combinational |
| pin_in | input | 32 | Raw pin levels |
| pin_out | output | 32 | Pin drive values |
| pin_oe | output | 32 | Pin drive enables |
| irq_en | output | 32 | Interrupt enables to the detector |
| irq_type | output | 32 | Interrupt type bits to the detector |
| irq_clr | output | 32 | One-cycle per-pin status clear strobes |
| irq_sta | input | 32 | Interrupt status from the detector |

## Verification
The assertions check the following on every cycle:
- A masked write with an all-zero mask leaves output data untouched.
- A plain enable write lands in the next cycle.
- No register changes in the cycle after a clear strobe.
- Writes outside both windows disturb nothing.
- The input register trails pin_in by exactly two edges.

Other properties depend on address and data choices, and only the bench's scenarios show them: the mixed masks across each register kind, the unused alias slots, status pass-through, and the derived pin drive. The bench uses a behavioural model and compares every output each cycle.

// File: rtl/gpio_mask_bank.sv
module gpio_mask_bank #(
  parameter int BANK_ID     = 1,
  parameter int BANK_STRIDE = 256,
  parameter int ALT_OFFSET  = 128,
  parameter int AW          = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  input  logic [31:0]   pin_in,
  output logic [31:0]   pin_out,
  output logic [31:0]   pin_oe,
  output logic [31:0]   irq_en,
  output logic [31:0]   irq_type,
  output logic [31:0]   irq_clr,
  input  logic [31:0]   irq_sta
);
  localparam int WIN = 128;
  localparam logic [AW-1:0] N_LO = AW'(BANK_ID * BANK_STRIDE);
  localparam logic [AW-1:0] N_HI = AW'(BANK_ID * BANK_STRIDE + WIN - 1);
  localparam logic [AW-1:0] A_LO = AW'(BANK_ID * BANK_STRIDE + ALT_OFFSET);
  localparam logic [AW-1:0] A_HI = AW'(BANK_ID * BANK_STRIDE + ALT_OFFSET + WIN - 1);

  logic [3:0][7:0] cfg_q, oe_q, out_q, en_q, typ_q, s1_q, s2_q, sta_v, clr_v;
  logic hit_n, hit_a, wr_hit;
  logic [AW-1:0] off;
  logic [2:0] kind;
  logic [1:0] port;
  logic [7:0] wmask;
  logic [1:0] age_q;
  logic unused_bits;

  function automatic logic [7:0] merge(input logic [7:0] old, input logic [7:0] m,
                                       input logic [7:0] v);
    return (old & ~m) | (v & m);
  endfunction

  assign hit_n  = (addr >= N_LO) && (addr <= N_HI);
  assign hit_a  = (addr >= A_LO) && (addr <= A_HI);
  assign off    = hit_a ? addr - A_LO : addr - N_LO;
  assign kind   = off[6:4];
  assign port   = off[3:2];
  assign wmask  = hit_a ? wdata[15:8] : 8'hFF;
  assign wr_hit = wr_en && (hit_n || hit_a);
  assign sta_v  = irq_sta;
  assign unused_bits = ^{wdata[31:16], off[AW-1:7], off[1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0; oe_q <= '0; out_q <= '0; en_q <= '0; typ_q <= '0;
      s1_q  <= '0; s2_q <= '0; age_q <= '0;
    end else begin
      s1_q <= pin_in;
      s2_q <= s1_q;
      if (age_q != 2'd2) age_q <= age_q + 2'd1;
      if (wr_hit) begin
        case (kind)
          3'd0: cfg_q[port] <= merge(cfg_q[port], wmask, wdata[7:0]);
          3'd1: oe_q[port]  <= merge(oe_q[port],  wmask, wdata[7:0]);
          3'd2: out_q[port] <= merge(out_q[port], wmask, wdata[7:0]);
          3'd5: en_q[port]  <= merge(en_q[port],  wmask, wdata[7:0]);
          3'd6: typ_q[port] <= merge(typ_q[port], wmask, wdata[7:0]);
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (hit_n || hit_a) begin
      case (kind)
        3'd0: rdata[7:0] = cfg_q[port];
        3'd1: rdata[7:0] = oe_q[port];
        3'd2: rdata[7:0] = out_q[port];
        3'd3: if (!hit_a) rdata[7:0] = s2_q[port];
        3'd4: rdata[7:0] = sta_v[port];
        3'd5: rdata[7:0] = en_q[port];
        3'd6: rdata[7:0] = typ_q[port];
        default: ;
      endcase
    end
  end

  always_comb begin
    clr_v = '0;
    if (wr_en && hit_n && kind == 3'd7) clr_v[port] = wdata[7:0];
  end

  assign irq_clr  = clr_v;
  assign pin_oe   = cfg_q & oe_q;
  assign pin_out  = out_q & pin_oe;
  assign irq_en   = en_q;
  assign irq_type = typ_q;

  p_mask_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit_a && kind == 3'd2 && wdata[15:8] == 8'h00) |=> $stable(out_q));

  p_plain_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit_n && kind == 3'd5) |=> (en_q[$past(port)] == $past(wdata[7:0])));

  p_clr_no_store_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr != 32'h0) |=> ($stable(cfg_q) && $stable(oe_q) && $stable(out_q)
                            && $stable(en_q) && $stable(typ_q)));

  p_outside_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !hit_n && !hit_a) |=> ($stable(cfg_q) && $stable(oe_q) && $stable(out_q)
                                     && $stable(en_q) && $stable(typ_q)));

  p_sync_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd2) |-> (s2_q == $past(pin_in, 2)));
endmodule

// File: tb/gpio_mask_bank_tb.sv
module gpio_mask_bank_tb_top;
  localparam int BID = 1, STR = 256, ALT = 128;
  localparam int NB = BID * STR, AB = NB + ALT;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, pin_in = '0, irq_sta = '0;
  logic [31:0] rdata, pin_out, pin_oe, irq_en, irq_type, irq_clr;
  int n_cmp = 0, n_bad = 0;
  string tag = "R1";

  logic [7:0] m_cfg[4], m_oe[4], m_out[4], m_en[4], m_typ[4];
  logic [31:0] m_s1, m_s2;

  always #10 clk = ~clk;

  gpio_mask_bank #(.BANK_ID(BID), .BANK_STRIDE(STR), .ALT_OFFSET(ALT), .AW(12)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq_en(irq_en),
    .irq_type(irq_type), .irq_clr(irq_clr), .irq_sta(irq_sta));

  function automatic bit decode(input logic [11:0] a, output bit al, output int k, output int p);
    int ia = int'(a);
    int o;
    if (ia >= NB && ia < NB + 128) begin o = ia - NB; al = 0; end
    else if (ia >= AB && ia < AB + 128) begin o = ia - AB; al = 1; end
    else return 0;
    k = o / 16; p = (o / 4) % 4;
    return 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        m_cfg[i] = 0; m_oe[i] = 0; m_out[i] = 0; m_en[i] = 0; m_typ[i] = 0;
      end
      m_s1 = 0; m_s2 = 0;
    end else begin
      bit al; int k, p;
      logic [7:0] m, v;
      m_s2 = m_s1; m_s1 = pin_in;
      if (wr_en && decode(addr, al, k, p)) begin
        m = al ? wdata[15:8] : 8'hFF; v = wdata[7:0];
        case (k)
          0: m_cfg[p] = (m_cfg[p] & ~m) | (v & m);
          1: m_oe[p]  = (m_oe[p]  & ~m) | (v & m);
          2: m_out[p] = (m_out[p] & ~m) | (v & m);
          5: m_en[p]  = (m_en[p]  & ~m) | (v & m);
          6: m_typ[p] = (m_typ[p] & ~m) | (v & m);
          default: ;
        endcase
      end
    end
  end

  task automatic cmp(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic check_all();
    bit al; int k, p;
    logic [31:0] e_rd = 0, e_clr = 0, e_oe, e_out, e_en, e_ty;
    for (int i = 0; i < 4; i++) begin
      e_oe[i*8 +: 8]  = m_cfg[i] & m_oe[i];
      e_out[i*8 +: 8] = m_cfg[i] & m_oe[i] & m_out[i];
      e_en[i*8 +: 8]  = m_en[i];
      e_ty[i*8 +: 8]  = m_typ[i];
    end
    if (decode(addr, al, k, p)) begin
      case (k)
        0: e_rd[7:0] = m_cfg[p];
        1: e_rd[7:0] = m_oe[p];
        2: e_rd[7:0] = m_out[p];
        3: e_rd[7:0] = al ? 8'h00 : m_s2[p*8 +: 8];
        4: e_rd[7:0] = irq_sta[p*8 +: 8];
        5: e_rd[7:0] = m_en[p];
        6: e_rd[7:0] = m_typ[p];
        default: ;
      endcase
      if (wr_en && !al && k == 7) e_clr[p*8 +: 8] = wdata[7:0];
    end
    cmp("rdata", rdata, e_rd);
    cmp("pin_oe", pin_oe, e_oe);
    cmp("pin_out", pin_out, e_out);
    cmp("irq_en", irq_en, e_en);
    cmp("irq_type", irq_type, e_ty);
    cmp("irq_clr", irq_clr, e_clr);
  endtask

  task automatic cyc(input string t, input bit w, input int a, input logic [31:0] d);
    @(negedge clk);
    check_all();
    tag = t; wr_en = w; addr = 12'(a); wdata = d;
  endtask

  task automatic rd(input string t, input int a);
    cyc(t, 0, a, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int k = 0; k < 8; k++)
      for (int p = 0; p < 4; p++) rd("R1", NB + k*16 + p*4);
    for (int p = 0; p < 4; p++) begin
      cyc("R2", 1, NB + 16'h00 + p*4, 32'hA5 ^ p);
      cyc("R2", 1, NB + 16'h10 + p*4, 32'h3C + p);
      cyc("R2", 1, NB + 16'h20 + p*4 + 2, 32'hFFFF_FF0F);
      rd("R2", NB + 16'h20 + p*4);
    end
    for (int p = 0; p < 4; p++) begin
      cyc("R10", 1, NB + 16'h50 + p*4, 32'h81 << p);
      cyc("R10", 1, NB + 16'h60 + p*4, 32'h5A ^ (p*17));
      rd("R10", NB + 16'h50 + p*4);
    end
    cyc("R8", 1, NB + 16'h00, 32'hFF);
    cyc("R8", 1, NB + 16'h10, 32'h0F);
    cyc("R8", 1, NB + 16'h20, 32'h55);
    cyc("R8", 1, NB + 16'h00, 32'hF0);
    rd("R8", NB);
    cyc("R3", 1, AB + 16'h20, 32'h0000_00FF);
    rd("R3", AB + 16'h20);
    cyc("R3", 1, AB + 16'h20, 32'h0000_0301);
    cyc("R3", 1, AB + 16'h00 + 4, 32'h0000_8080);
    cyc("R3", 1, AB + 16'h10 + 8, 32'h0000_FF00);
    cyc("R3", 1, AB + 16'h50 + 12, 32'h0000_1234);
    cyc("R3", 1, AB + 16'h60 + 4, 32'h0000_FFFF);
    for (int k = 0; k < 7; k++) rd("R3", AB + k*16 + 4);
    pin_in = 32'hDEAD_BEEF;
    rd("R7", NB + 16'h30);
    rd("R7", NB + 16'h30);
    rd("R7", NB + 16'h34);
    rd("R7", NB + 16'h3C);
    pin_in = 32'h0123_4567;
    for (int i = 0; i < 3; i++) rd("R7", NB + 16'h38);
    cyc("R4", 1, AB + 16'h30, 32'h0000_FFFF);
    cyc("R4", 1, AB + 16'h70, 32'h0000_FFFF);
    rd("R4", AB + 16'h30);
    rd("R4", AB + 16'h74);
    cyc("R5", 1, NB + 16'h70 + 8, 32'h0000_00C3);
    cyc("R5", 1, NB + 16'h70, 32'h0000_0001);
    rd("R5", NB + 16'h7C);
    irq_sta = 32'h8421_F00D;
    rd("R6", NB + 16'h40);
    rd("R6", AB + 16'h4C);
    cyc("R6", 1, NB + 16'h44, 32'hFF);
    cyc("R6", 1, AB + 16'h48, 32'hFFFF);
    rd("R6", NB + 16'h48);
    cyc("R9", 1, 0, 32'hFF);
    cyc("R9", 1, NB - 4, 32'hFF);
    cyc("R9", 1, AB + 128, 32'hFFFF);
    cyc("R9", 1, 12'hFFC, 32'hFFFF);
    rd("R9", NB - 4);
    rd("R9", 12'hFFC);
    for (int i = 0; i < 400; i++) begin
      pin_in = $urandom;
      irq_sta = $urandom;
      cyc("R2", ($urandom % 2) == 1, int'($urandom % 1024) & 32'hFFC, $urandom);
    end
    rd("R2", NB);
    @(negedge clk);
    check_all();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual running expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule